// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Lookahead Carries

This block is a purely combinational 32-bit arithmetic and logic unit made of identical one-bit slices. Each slice receives one bit of each operand, an optional inversion of its B bit, a shared operation code and a carry. It returns one result bit together with the generate and propagate terms that feed a two-level carry lookahead network. All slice carries are therefore formed in parallel rather than passed from slice to slice.

The unit covers bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. A subtraction is requested by inverting B and forcing the carry into bit 0 high, which adds the two's complement of B to A. Alongside the result the block reports the carry out of the top bit, signed overflow, a signed less-than flag corrected for overflow, and an all-zero flag. A datapath uses it as the execute-stage ALU of a simple integer core and may register its outputs as it sees fit.

Top module: `bitslice_alu`

## Requirements
- R1: With op_i = 2'b00 the result is the bitwise AND of a_i and the effective B, where the effective B is ~b_i when b_invert_i = 1 and b_i otherwise.
- R2: With op_i = 2'b01 the result is the bitwise OR of a_i and the effective B.
- R3: With op_i = 2'b10 the result is (a_i + effective B + carry_i) modulo 2^32, and carry_o is bit 32 of that sum.
- R4: With b_invert_i = 1 and carry_i = 1 the adder path forms a_i - b_i; carry_o is then 1 exactly when a_i >= b_i as unsigned values.
- R5: For add and subtract, overflow_o is 1 exactly when the operation's signed result does not fit in 32 bits (carry into bit 31 differs from carry out of bit 31).
- R6: For a subtraction, less_o is bit 31 of the difference XOR overflow_o, so it is 1 exactly when a_i < b_i as signed values, including when the difference overflows.
- R7: With op_i = 2'b11, b_invert_i = 1 and carry_i = 1, result bits 31..1 are 0 and bit 0 equals the corrected less value of R6.
- R8: zero_o is 1 exactly when all 32 result bits are 0, for every operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B, before optional inversion |
| op_i | input | 2 | Operation: 00 AND, 01 OR, 10 add, 11 set-on-less-than |
| b_invert_i | input | 1 | Use ~b_i in every slice instead of b_i |
| carry_i | input | 1 | Carry into bit 0; 1 for subtract and set-on-less-than |
| result_o | output | 32 | Selected result |
| carry_o | output | 1 | Carry out of bit 31 |
| overflow_o | output | 1 | Signed overflow of the adder path |
| less_o | output | 1 | Overflow-corrected sign of the adder path |
| zero_o | output | 1 | 1 when result_o is all zeros |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus with no register between them. The bench changes the inputs just after a rising edge and samples all outputs at the following falling edge, half a period later, when the lookahead network has long settled. Carry, overflow and less are compared only for the add and set-on-less-than codes, while result and zero are compared for every code.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_ADD = 2'b10,
    OP_SLT = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    b_invert_i,
  input  logic    cin_i,
  input  logic    set_i,
  input  alu_op_e op_i,
  output logic    res_o,
  output logic    sum_o,
  output logic    gen_o,
  output logic    prop_o
);
  logic b_eff;

  assign b_eff  = b_invert_i ? ~b_i : b_i;
  assign gen_o  = a_i & b_eff;
  assign prop_o = a_i ^ b_eff;
  assign sum_o  = prop_o ^ cin_i;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_eff;
      OP_OR:   res_o = a_i | b_eff;
      OP_ADD:  res_o = sum_o;
      default: res_o = set_i;
    endcase
  end
endmodule

// File: rtl/cla_group.sv
// First lookahead level: carries inside one group plus group generate/propagate.
module cla_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] gen_i,
  input  logic [GW-1:0] prop_i,
  input  logic          cin_i,
  output logic [GW-2:0] carry_o,   // carry_o[k] = carry into bit k+1
  output logic          grp_gen_o,
  output logic          grp_prop_o
);
  always_comb begin
    for (int k = 0; k < GW - 1; k++) begin
      logic c, run;
      c   = 1'b0;
      run = 1'b1;
      for (int j = k; j >= 0; j--) begin
        c   = c | (gen_i[j] & run);
        run = run & prop_i[j];
      end
      carry_o[k] = c | (run & cin_i);
    end
  end

  always_comb begin
    logic c, run;
    c   = 1'b0;
    run = 1'b1;
    for (int j = GW - 1; j >= 0; j--) begin
      c   = c | (gen_i[j] & run);
      run = run & prop_i[j];
    end
    grp_gen_o  = c;
    grp_prop_o = run;
  end

  // Expanded carries agree with the per-bit recurrence (R3).
  always_comb begin
    if (GW > 2) begin
      for (int k = 1; k < GW - 1; k++) begin
        p_grp_recur_r3: assert (carry_o[k] == (gen_i[k] | (prop_i[k] & carry_o[k-1])))
          else $error("group carry %0d breaks recurrence", k);
      end
    end
    p_grp_first_r3: assert (carry_o[0] == (gen_i[0] | (prop_i[0] & cin_i)))
      else $error("group carry 0 breaks recurrence");
  end
endmodule

// File: rtl/cla_net.sv
// Second lookahead level: carry out of every group from group terms.
module cla_net #(
  parameter int unsigned NG = 8
) (
  input  logic [NG-1:0] grp_gen_i,
  input  logic [NG-1:0] grp_prop_i,
  input  logic          cin_i,
  output logic [NG-1:0] carry_o    // carry_o[j] = carry out of group j
);
  always_comb begin
    for (int k = 0; k < NG; k++) begin
      logic c, run;
      c   = 1'b0;
      run = 1'b1;
      for (int j = k; j >= 0; j--) begin
        c   = c | (grp_gen_i[j] & run);
        run = run & grp_prop_i[j];
      end
      carry_o[k] = c | (run & cin_i);
    end
  end

  always_comb begin
    p_net_first_r3: assert (carry_o[0] == (grp_gen_i[0] | (grp_prop_i[0] & cin_i)))
      else $error("group 0 carry mismatch");
    for (int k = 1; k < NG; k++) begin
      p_net_recur_r3: assert (carry_o[k] == (grp_gen_i[k] | (grp_prop_i[k] & carry_o[k-1])))
        else $error("group %0d carry mismatch", k);
    end
  end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned GW    = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  input  logic             b_invert_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             overflow_o,
  output logic             less_o,
  output logic             zero_o
);
  localparam int unsigned NG = WIDTH / GW;

  alu_op_e          op;
  logic [WIDTH-1:0] gen, prop, sum;
  logic [WIDTH:0]   carry;        // carry[i] = carry into bit i
  logic [NG-1:0]    grp_gen, grp_prop, grp_cout;

  assign op       = alu_op_e'(op_i);
  assign carry[0] = carry_i;

  for (genvar s = 0; s < WIDTH; s++) begin : g_slice
    logic set;
    if (s == 0) begin : g_lsb
      assign set = less_o;
    end else begin : g_rest
      assign set = 1'b0;
    end
    alu_slice i_slice (
      .a_i        (a_i[s]),
      .b_i        (b_i[s]),
      .b_invert_i (b_invert_i),
      .cin_i      (carry[s]),
      .set_i      (set),
      .op_i       (op),
      .res_o      (result_o[s]),
      .sum_o      (sum[s]),
      .gen_o      (gen[s]),
      .prop_o     (prop[s])
    );
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    cla_group #(.GW(GW)) i_grp (
      .gen_i      (gen[g*GW +: GW]),
      .prop_i     (prop[g*GW +: GW]),
      .cin_i      (carry[g*GW]),
      .carry_o    (carry[g*GW+1 +: GW-1]),
      .grp_gen_o  (grp_gen[g]),
      .grp_prop_o (grp_prop[g])
    );
    assign carry[(g+1)*GW] = grp_cout[g];
  end

  cla_net #(.NG(NG)) i_net (
    .grp_gen_i  (grp_gen),
    .grp_prop_i (grp_prop),
    .cin_i      (carry_i),
    .carry_o    (grp_cout)
  );

  assign carry_o    = carry[WIDTH];
  assign overflow_o = carry[WIDTH-1] ^ carry[WIDTH];
  assign less_o     = sum[WIDTH-1] ^ overflow_o;
  assign zero_o     = ~(|result_o);

  // Reference checks against a plain arithmetic model.
  logic [WIDTH-1:0] b_ref;
  logic [WIDTH:0]   add_ref;
  assign b_ref   = b_invert_i ? ~b_i : b_i;
  assign add_ref = {1'b0, a_i} + {1'b0, b_ref} + {{WIDTH{1'b0}}, carry_i};

  always_comb begin
    p_add_r3: assert ({carry_o, sum} == add_ref)
      else $error("adder path mismatch");
    p_overflow_r5: assert (overflow_o ==
        ((a_i[WIDTH-1] == b_ref[WIDTH-1]) && (add_ref[WIDTH-1] != a_i[WIDTH-1])))
      else $error("overflow mismatch");
    if (op == OP_AND) begin
      p_and_r1: assert (result_o == (a_i & b_ref)) else $error("AND mismatch");
    end
    if (op == OP_OR) begin
      p_or_r2: assert (result_o == (a_i | b_ref)) else $error("OR mismatch");
    end
    if (op == OP_SLT) begin
      p_slt_upper_r7: assert (result_o[WIDTH-1:1] == '0 && result_o[0] == less_o)
        else $error("SLT result mismatch");
    end
  end
endmodule

// File: tb/test_bitslice_alu.sv
module test_bitslice_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic [1:0]  op;
  logic        binv, cin, cout, ovf, less, zero;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  bitslice_alu i_bitslice_alu (
    .a_i(a), .b_i(b), .op_i(op), .b_invert_i(binv), .carry_i(cin),
    .result_o(res), .carry_o(cout), .overflow_o(ovf), .less_o(less), .zero_o(zero)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        binv;
    logic        cin;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        cout;
    logic        ovf;
    logic        less;
    logic        zero;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'b01, 1'b0, 1'b0, 32'h0F0F0000, 32'h000000FF, 32'h0F0F00FF, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'b00, 1'b1, 1'b0, 32'hFFFF0000, 32'h00FF00FF, 32'hFF000000, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'b10, 1'b0, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'b10, 1'b1, 1'b1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b1, 1'b1, 1'b0},
    '{2'b10, 1'b1, 1'b1, 32'h12345678, 32'h12345678, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'b11, 1'b1, 1'b1, 32'h00000005, 32'h00000007, 32'h00000001, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'b11, 1'b1, 1'b1, 32'h00000007, 32'h00000005, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'b11, 1'b1, 1'b1, 32'h80000000, 32'h00000001, 32'h00000001, 1'b1, 1'b1, 1'b1, 1'b0},
    '{2'b10, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'b10, 1'b0, 1'b1, 32'h00000001, 32'h00000002, 32'h00000004, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'b01, 1'b0, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b1},
    '{2'b00, 1'b0, 1'b0, 32'h0000FFFF, 32'hFFFF0000, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  function automatic vec_t model(logic [1:0] m_op, logic m_binv, logic m_cin,
                                 logic [31:0] m_a, logic [31:0] m_b);
    vec_t        v;
    logic [31:0] be;
    logic [32:0] s;
    be     = m_binv ? ~m_b : m_b;
    s      = {1'b0, m_a} + {1'b0, be} + {32'd0, m_cin};
    v      = '0;
    v.op   = m_op; v.binv = m_binv; v.cin = m_cin; v.a = m_a; v.b = m_b;
    v.cout = s[32];
    v.ovf  = (m_a[31] == be[31]) && (s[31] != m_a[31]);
    v.less = s[31] ^ v.ovf;
    case (m_op)
      2'b00:   v.res = m_a & be;
      2'b01:   v.res = m_a | be;
      2'b10:   v.res = s[31:0];
      default: v.res = {31'd0, v.less};
    endcase
    v.zero = (v.res == 32'd0);
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(vec_t v, string tag);
    @(posedge clk);
    #1;
    op = v.op; binv = v.binv; cin = v.cin; a = v.a; b = v.b;
    @(negedge clk);
    case (v.op)
      2'b00: check({tag, " R1 result"}, res, v.res);
      2'b01: check({tag, " R2 result"}, res, v.res);
      2'b10: check({tag, (v.binv ? " R4 result" : " R3 result")}, res, v.res);
      default: check({tag, " R7 result"}, res, v.res);
    endcase
    check({tag, " R8 zero"}, {31'd0, zero}, {31'd0, v.zero});
    if (v.op[1]) begin
      check({tag, (v.binv ? " R4 carry" : " R3 carry")}, {31'd0, cout}, {31'd0, v.cout});
      check({tag, " R5 overflow"}, {31'd0, ovf}, {31'd0, v.ovf});
      if (v.binv && v.cin)
        check({tag, " R6 less"}, {31'd0, less}, {31'd0, v.less});
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    op = 2'b00; binv = 1'b0; cin = 1'b0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset-state inputs: AND of zeros
    check("reset R1 result", res, 32'd0);
    check("reset R8 zero", {31'd0, zero}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      vec_t m;
      m = model(VECS[i].op, VECS[i].binv, VECS[i].cin, VECS[i].a, VECS[i].b);
      check("table self R3", m.res, VECS[i].res);
      apply(VECS[i], $sformatf("vec%0d", i));
    end

    // random vectors: logic ops with both B polarities, add, subtract, slt
    void'($urandom(32'h5EED));
    for (int i = 0; i < 300; i++) begin
      logic [1:0]  r_op;
      logic        r_binv, r_cin;
      logic [31:0] r_a, r_b;
      r_op   = 2'(i % 4);
      r_a    = $urandom();
      r_b    = (i % 17 == 0) ? r_a : $urandom();
      r_binv = (r_op == 2'b11) ? 1'b1 : 1'(($urandom() >> 3) & 1);
      r_cin  = (r_op == 2'b11) ? 1'b1 : (r_op == 2'b10 && r_binv) ? 1'b1 : 1'(($urandom() >> 5) & 1);
      apply(model(r_op, r_binv, r_cin, r_a, r_b), $sformatf("rnd%0d", i));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule